// File: doc/BRIEF.md
# Eight-Entry Register Bank with Opcode-Driven Write Source

This block holds the architectural state of a small single-cycle datapath: eight registers, each twelve bits wide, whose contents are all presented at the outputs at once. Downstream logic picks operands out of that wide bus; this block only stores values and accepts one write per clock.

One write port is steered by a three-bit destination index and a write enable. The value stored is chosen inside the block from the four-bit opcode of the instruction in flight. A load-immediate opcode stores the immediate field, a read-program-counter opcode stores the current program counter, and every other opcode stores the ALU result. Entry 0 is an ordinary register and is not tied to zero. A synchronous reset clears the whole bank.

Top module: `opsel_regfile`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register reads 0 after that edge.
- R2: With `rst` low and `wr_en` high at a rising edge, the register numbered `wr_idx` takes the selected write value after that edge.
- R3: When `opcode` is 4'b1001, the value written is `imm_val`.
- R4: When `opcode` is 4'b1000, the value written is `pc_val`.
- R5: For every opcode other than 4'b1000 and 4'b1001, the value written is `alu_res`.
- R6: During a write, every register whose number differs from `wr_idx` keeps its value.
- R7: With `wr_en` low and `rst` low, no register changes, whatever the other inputs hold.
- R8: When `rst` and `wr_en` are both high at the same edge, the bank clears and the write is dropped.
- R9: Register 0 is writable and holds any written value, including nonzero ones.
- R10: Register i is presented on `regs_o[12*i+11 : 12*i]`, continuously, with no read latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| wr_en | input | 1 | Write enable for the single write port |
| wr_idx | input | 3 | Number of the register to write |
| opcode | input | 4 | Opcode of the current instruction, chooses the write source |
| alu_res | input | 12 | ALU result, default write source |
| pc_val | input | 12 | Program counter value, written under opcode 4'b1000 |
| imm_val | input | 12 | Immediate field, written under opcode 4'b1001 |
| regs_o | output | 96 | All eight registers, register i in bits 12*i+11 down to 12*i |

## Verification
The three sources are always driven with distinct values, so a write that lands with the wrong source shows up as a wrong number rather than a coincidental match. Directed steps write every index in turn with each source class, sweep all sixteen opcodes into one register, hold `wr_en` low while the data inputs toggle, and raise reset together with a write to tell reset priority apart from a late write. A long stretch of random enables, indices and opcodes against a behavioural model catches cross-talk between entries, such as a decode that hits two registers or a bank that ignores the index.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_DW     = 12;
    localparam int RF_NREGS  = 8;
    localparam int RF_IDXW   = $clog2(RF_NREGS);
    localparam int RF_OPW    = 4;

    localparam logic [RF_OPW-1:0] OP_LOAD_PC  = 4'b1000;
    localparam logic [RF_OPW-1:0] OP_LOAD_IMM = 4'b1001;

    typedef enum logic [1:0] {
        SRC_ALU = 2'd0,
        SRC_PC  = 2'd1,
        SRC_IMM = 2'd2
    } wsrc_e;

    function automatic wsrc_e classify_op(input logic [RF_OPW-1:0] op);
        wsrc_e s;
        unique case (op)
            OP_LOAD_PC:  s = SRC_PC;
            OP_LOAD_IMM: s = SRC_IMM;
            default:     s = SRC_ALU;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rf_src_mux.sv
module rf_src_mux
    import rf_pkg::*;
#(
    parameter int DW  = RF_DW,
    parameter int OPW = RF_OPW
) (
    input  logic [OPW-1:0] opcode,
    input  logic [DW-1:0]  alu_res,
    input  logic [DW-1:0]  pc_val,
    input  logic [DW-1:0]  imm_val,
    output logic [DW-1:0]  wdata
);

    wsrc_e src;

    always_comb begin
        src = classify_op(opcode);
    end

    always_comb begin
        unique case (src)
            SRC_PC:  wdata = pc_val;
            SRC_IMM: wdata = imm_val;
            default: wdata = alu_res;
        endcase
    end

endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    output logic [NREGS-1:0] we_vec
);

    always_comb begin
        we_vec = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (wr_en && (wr_idx == IDXW'(i)))
                we_vec[i] = 1'b1;
        end
    end

    // R2 / R6: at most one entry strobed, exactly one when enabled
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_vec));
    a_r2_strobe_on_enable: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(we_vec) == 1));

endmodule

// File: rtl/rf_cell.sv
module rf_cell #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end

    // R1 / R8: reset clears the cell even with a strobe present
    a_r8_reset_wins: assert property (@(posedge clk)
        rst |=> (q == '0));
    // R6: an unstrobed cell keeps its contents
    a_r6_cell_holds: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/opsel_regfile.sv
module opsel_regfile
    import rf_pkg::*;
#(
    parameter int DW    = RF_DW,
    parameter int NREGS = RF_NREGS,
    parameter int OPW   = RF_OPW,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDXW-1:0]     wr_idx,
    input  logic [OPW-1:0]      opcode,
    input  logic [DW-1:0]       alu_res,
    input  logic [DW-1:0]       pc_val,
    input  logic [DW-1:0]       imm_val,
    output logic [NREGS*DW-1:0] regs_o
);

    logic [DW-1:0]    wdata;
    logic [NREGS-1:0] we_vec;
    logic [DW-1:0]    q_arr [NREGS];

    rf_src_mux #(.DW(DW), .OPW(OPW)) u_src (
        .opcode  (opcode),
        .alu_res (alu_res),
        .pc_val  (pc_val),
        .imm_val (imm_val),
        .wdata   (wdata)
    );

    rf_wr_decode #(.NREGS(NREGS)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .we_vec (we_vec)
    );

    for (genvar g = 0; g < NREGS; g++) begin : g_cell
        rf_cell #(.DW(DW)) u_cell (
            .clk (clk),
            .rst (rst),
            .we  (we_vec[g]),
            .d   (wdata),
            .q   (q_arr[g])
        );
        // R10: register g on its own fixed slice
        assign regs_o[g*DW +: DW] = q_arr[g];
    end

    // R3: load-immediate opcode stores the immediate
    a_r3_imm_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && opcode == OP_LOAD_IMM) |=> (q_arr[$past(wr_idx)] == $past(imm_val)));
    // R4: read-pc opcode stores the program counter
    a_r4_pc_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && opcode == OP_LOAD_PC) |=> (q_arr[$past(wr_idx)] == $past(pc_val)));
    // R5: all other opcodes store the ALU result
    a_r5_alu_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && opcode != OP_LOAD_PC && opcode != OP_LOAD_IMM)
            |=> (q_arr[$past(wr_idx)] == $past(alu_res)));
    // R7: no enable, no change anywhere in the bank
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_o));

endmodule

// File: tb/opsel_regfile_tb.sv
`timescale 1ns/1ps
module opsel_regfile_tb;

    localparam int DW = 12;
    localparam int NR = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_idx = '0;
    logic [3:0]      opcode = '0;
    logic [DW-1:0]   alu_res = '0;
    logic [DW-1:0]   pc_val = '0;
    logic [DW-1:0]   imm_val = '0;
    logic [NR*DW-1:0] regs_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] mdl [NR];

    always #2.5 clk = ~clk;

    opsel_regfile u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .opcode(opcode),
        .alu_res(alu_res), .pc_val(pc_val), .imm_val(imm_val), .regs_o(regs_o)
    );

    task automatic compare(input string tag);
        checks++;
        for (int i = 0; i < NR; i++) begin
            if (regs_o[i*DW +: DW] !== mdl[i]) begin
                errors++;
                $display("FAIL %s reg%0d actual %h expected %h", tag, i, regs_o[i*DW +: DW], mdl[i]);
            end
        end
    endtask

    // apply one cycle of stimulus, advance the model, compare after the edge
    task automatic step(input bit r, input bit we, input int idx, input int op,
                        input int a, input int p, input int im, input string tag);
        logic [DW-1:0] wv;
        @(negedge clk);
        rst = r; wr_en = we; wr_idx = 3'(idx); opcode = 4'(op);
        alu_res = DW'(a); pc_val = DW'(p); imm_val = DW'(im);
        if (op == 9) wv = DW'(im);
        else if (op == 8) wv = DW'(p);
        else wv = DW'(a);
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < NR; i++) mdl[i] = '0;
        end else if (we) begin
            mdl[idx] = wv;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) mdl[i] = 'x;
        // R1: reset clears the bank
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // R2 R3 R10: immediate into each index with distinct values
        for (int i = 0; i < NR; i++)
            step(0, 1, i, 9, 12'h111, 12'h222, 12'hA00 + i, "R3_R10");
        // R4: program counter into each index
        for (int i = 0; i < NR; i++)
            step(0, 1, i, 8, 12'h333, 12'h0C0 + i, 12'h444, "R4");
        // R5: every other opcode uses ALU result, sweep into one register
        for (int op = 0; op < 16; op++)
            step(0, 1, 5, op, 12'h500 + op, 12'h6AA, 12'h7BB, "R5");
        // R9: register 0 holds nonzero written data
        step(0, 1, 0, 3, 12'hFFF, 12'h001, 12'h002, "R9");
        step(0, 0, 0, 3, 12'h000, 12'h000, 12'h000, "R9");
        // R7: inputs toggle with enable low
        step(0, 0, 2, 9, 12'h0AB, 12'hCDE, 12'hF01, "R7");
        step(0, 0, 7, 8, 12'h123, 12'h456, 12'h789, "R7");
        // R6: write one index, others unchanged
        step(0, 1, 3, 4, 12'h5A5, 12'h111, 12'h222, "R6");
        // R8: reset with a simultaneous write
        step(1, 1, 4, 9, 12'h001, 12'h002, 12'hABC, "R8");
        // R2 R6: random traffic
        for (int n = 0; n < 400; n++)
            step(($urandom % 50) == 0, $urandom % 2, $urandom % NR, $urandom % 16,
                 $urandom % 4096, $urandom % 4096, $urandom % 4096, "R2_R6");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule